// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a three-wire serial peripheral port with a slave-select line. It can act as the bus master or as a slave. As master it makes the serial clock from the system clock through a 16-bit divisor. It shifts a word out on the data-out line and takes a word in on the data-in line. As slave it follows an external serial clock and select. Clock polarity, clock phase and word length (8 or 16 bits) are programmable. Data always travels most significant bit first.

Software writes a word to start or arm a transfer. Once the last bit is sampled, the received word appears on a read port. At that point a one-cycle completion interrupt fires, and when DMA is enabled a one-cycle DMA request strobe fires with it. In broadcast mode several slaves share one select line and all receive the same word. Each slave keeps its return-data driver off, so only the master drives the bus.

Top module: `spi_port`

## Requirements
- R1: After reset, `busy`, `done_irq` and `dma_req` are 0 and `rx_data` is 0. With slave mode selected and the select input high, `miso_oe` is 0. While idle, `sck_o` equals `cfg_cpol`.
- R2: In master mode, a `tx_wr` seen while idle starts a transfer. Serial clock edge number i (counting from 1) appears on `sck_o` exactly i×D system cycles after the cycle that accepted `tx_wr`. D is the effective divisor. The transfer has 2×L edges, where L is the word length. `busy` stays 1 until the last edge, and `sck_o` then rests at `cfg_cpol`.
- R3: The effective divisor D is `cfg_baud` when it is 2 or more. Values 0 and 1 behave as 2, so the fastest serial clock is one quarter of the system clock.
- R4: `cfg_wide`=1 selects 16-bit words and `cfg_wide`=0 selects 8-bit words. In 8-bit mode only `tx_data[7:0]` is sent, and `rx_data[15:8]` reads 0.
- R5: Bits go out MSB first. With `cfg_cpha`=0, the first bit is on the data output from the start and the next bit follows each even-numbered edge. With `cfg_cpha`=1, each bit is placed on an odd-numbered edge.
- R6: The master samples `miso_i` on the sampling edges: odd-numbered edges when `cfg_cpha`=0, even-numbered edges when `cfg_cpha`=1. The received word appears on `rx_data` in the cycle after the last sampling edge.
- R7: `done_irq` is high for exactly one cycle, in the cycle after the last sampling edge of a word, in both master and slave mode.
- R8: `dma_req` pulses together with `done_irq` when `cfg_dma_en`=1 and never when it is 0.
- R9: In slave mode the port follows `sck_i`, `mosi_i` and `ss_n_i` through a two-stage synchronizer. Each external edge takes effect on the third system clock after it occurs. The port returns the loaded word on `miso_o` and receives the word on `mosi_i`, using the same polarity and phase rules.
- R10: `miso_oe` is 1 only in slave mode, with the select low and `cfg_bcast`=0. In broadcast mode the slave still receives the word and raises `done_irq`.
- R11: Raising `ss_n_i` mid-word discards the partial slave word: no `done_irq`, and the next word is received correctly from its first bit.
- R12: A `tx_wr` while the master is busy is ignored. The data output and the transfer length are unchanged, and no new transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cfg_wide | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| cfg_bcast | input | 1 | Broadcast: slave return driver kept off |
| cfg_dma_en | input | 1 | Enables the DMA request strobe |
| cfg_baud | input | 16 | Master clock divisor (half period in system cycles) |
| tx_data | input | 16 | Word to send |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| rx_data | output | 16 | Last received word |
| done_irq | output | 1 | One-cycle word-complete interrupt |
| dma_req | output | 1 | One-cycle DMA request |
| busy | output | 1 | Master transfer in progress |
| sck_o | output | 1 | Master serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Data in (slave) |
| miso_i | input | 1 | Data in (master) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Slave select in, active low |
| ss_n_o | output | 1 | Slave select out, low while master busy |

## Verification
In master mode every output is due on a known cycle. Edge i lands i×D cycles after the accepting clock, and `done_irq`, `dma_req` and `rx_data` follow one cycle after the last sampling edge. The reference model therefore predicts `sck_o`, `mosi_o`, `busy`, `done_irq` and `dma_req` for every cycle and compares them half a period after each edge. In slave mode the bench plays master with a six-cycle half period. It checks that the completion pulse comes exactly three system cycles after the final sampling toggle. It samples `miso_o` at its own sampling toggles, well after the slave's drive point.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int unsigned SPI_DW = 16;
    localparam int unsigned SPI_NW = 8;
    localparam int unsigned SPI_BW = 16;
    localparam int unsigned SPI_EW = $clog2(2 * SPI_DW + 1);

    typedef logic [SPI_DW-1:0] spi_word_t;
    typedef logic [SPI_EW-1:0] spi_edge_t;

    typedef struct packed {
        logic      busy;
        spi_edge_t edges;
        logic      sck;
        spi_word_t rx;
        logic      done;
        logic      dma;
    } spi_ctl_t;

    typedef struct packed {
        spi_word_t sh;
        logic      sout;
    } spi_shf_t;

    function automatic spi_word_t spi_fit(input spi_word_t v, input logic wide);
        spi_word_t m;
        m = '0;
        m[SPI_NW-1:0] = '1;
        return wide ? v : (v & m);
    endfunction
endpackage

// File: rtl/spi_baud.sv
module spi_baud #(
    parameter int unsigned BW = spi_port_pkg::SPI_BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [BW-1:0] baud,
    output logic          tick
);
    localparam logic [BW-1:0] MIN_DIV = BW'(2);

    logic [BW-1:0] cnt_q, cnt_d, div;

    always_comb begin
        div   = (baud < MIN_DIV) ? MIN_DIV : baud;
        tick  = run && (cnt_q == div - 1'b1);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a half period is never shorter than two system cycles
    p_min_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q != '0));
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ss_n_i,
    output logic mosi_s,
    output logic ss_n_s,
    output logic sck_edge
);
    logic [2:0] chain_q [STAGES];
    logic [2:0] chain_d [STAGES];
    logic       prev_q, prev_d;

    always_comb begin
        chain_d[0] = {ss_n_i, mosi_i, sck_i};
        for (int k = 1; k < STAGES; k++) chain_d[k] = chain_q[k-1];
        prev_d   = chain_q[STAGES-1][0];
        sck_edge = chain_q[STAGES-1][0] ^ prev_q;
        mosi_s   = chain_q[STAGES-1][1];
        ss_n_s   = chain_q[STAGES-1][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= 3'b100;
            prev_q <= 1'b0;
        end else begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= chain_d[k];
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  spi_word_t load_val,
    input  logic      wide,
    input  logic      drive,
    input  logic      sample,
    input  logic      sin,
    output spi_word_t word,
    output logic      sout
);
    spi_shf_t s_q, s_d;
    logic     msb;

    always_comb begin
        s_d = s_q;
        msb = wide ? s_q.sh[SPI_DW-1] : s_q.sh[SPI_NW-1];
        if (load) begin
            s_d.sh   = spi_fit(load_val, wide);
            s_d.sout = wide ? load_val[SPI_DW-1] : load_val[SPI_NW-1];
        end else begin
            if (drive)  s_d.sout = msb;
            if (sample) s_d.sh   = {s_q.sh[SPI_DW-2:0], sin};
        end
        word = s_q.sh;
        sout = s_q.sout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a serial edge either drives or samples, never both
    p_edge_role_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive && sample));
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_wide,
    input  logic              cfg_bcast,
    input  logic              cfg_dma_en,
    input  logic [SPI_BW-1:0] cfg_baud,
    input  logic [SPI_DW-1:0] tx_data,
    input  logic              tx_wr,
    output logic [SPI_DW-1:0] rx_data,
    output logic              done_irq,
    output logic              dma_req,
    output logic              busy,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i,
    output logic              ss_n_o
);
    spi_ctl_t  c_q, c_d;
    spi_word_t word;
    logic      tick, mosi_s, ss_s, sck_edge, sout;
    logic      ev, smp, drv, last_smp, sin, start, ld;
    spi_edge_t len2, nxt;

    spi_baud #(.BW(SPI_BW)) i_baud (
        .clk(clk), .rst_n(rst_n), .run(c_q.busy), .baud(cfg_baud), .tick(tick)
    );

    spi_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
        .mosi_s(mosi_s), .ss_n_s(ss_s), .sck_edge(sck_edge)
    );

    spi_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(tx_data), .wide(cfg_wide),
        .drive(drv), .sample(smp), .sin(sin), .word(word), .sout(sout)
    );

    always_comb begin
        len2     = cfg_wide ? spi_edge_t'(2 * SPI_DW) : spi_edge_t'(2 * SPI_NW);
        nxt      = c_q.edges + 1'b1;
        ev       = cfg_master ? (c_q.busy & tick) : (sck_edge & ~ss_s);
        smp      = ev & (cfg_cpha ? ~nxt[0] : nxt[0]);
        drv      = ev & ~smp;
        last_smp = smp & (nxt == (cfg_cpha ? len2 : len2 - 1'b1));
        sin      = cfg_master ? miso_i : mosi_s;
        start    = cfg_master & tx_wr & ~c_q.busy;
        ld       = cfg_master ? start : (tx_wr & (c_q.edges == '0));

        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.dma  = 1'b0;
        if (cfg_master) begin
            if (start) begin
                c_d.busy  = 1'b1;
                c_d.edges = '0;
                c_d.sck   = cfg_cpol;
            end else if (ev) begin
                c_d.edges = nxt;
                c_d.sck   = ~c_q.sck;
                if (nxt == len2) begin
                    c_d.busy  = 1'b0;
                    c_d.edges = '0;
                end
            end
        end else begin
            c_d.busy = 1'b0;
            c_d.sck  = cfg_cpol;
            if (ss_s)    c_d.edges = '0;
            else if (ev) c_d.edges = (nxt == len2) ? '0 : nxt;
        end
        if (last_smp) begin
            c_d.rx   = spi_fit({word[SPI_DW-2:0], sin}, cfg_wide);
            c_d.done = 1'b1;
            c_d.dma  = cfg_dma_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign rx_data  = c_q.rx;
    assign done_irq = c_q.done;
    assign dma_req  = c_q.dma;
    assign busy     = c_q.busy;
    assign sck_o    = c_q.busy ? c_q.sck : cfg_cpol;
    assign sck_oe   = cfg_master;
    assign mosi_o   = sout;
    assign mosi_oe  = cfg_master;
    assign miso_o   = sout;
    assign miso_oe  = ~cfg_master & ~ss_s & ~cfg_bcast;
    assign ss_n_o   = ~(cfg_master & c_q.busy);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R8: a DMA strobe only accompanies a completion
    p_dma_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> done_irq);

    // R4: the edge count stays below the longest word
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.edges <= spi_edge_t'(2 * SPI_DW - 1));

    // R11: a deselected slave restarts at bit zero
    p_ss_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && ss_s) |=> (c_q.edges == '0));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_wide = 1'b1;
    logic        cfg_bcast = 1'b0, cfg_dma_en = 1'b0;
    logic [15:0] cfg_baud = 16'd2;
    logic [15:0] tx_data = '0;
    logic        tx_wr = 1'b0;
    logic [15:0] rx_data;
    logic        done_irq, dma_req, busy, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o;
    logic        sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

    int n_run = 0, n_fail = 0;
    int cyc_ct = 0, done_cnt = 0, dma_cnt = 0, done_at = 0;
    bit mon_on = 1'b0;

    always #4 clk = ~clk;

    spi_port i_spi_port (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_wide(cfg_wide), .cfg_bcast(cfg_bcast),
        .cfg_dma_en(cfg_dma_en), .cfg_baud(cfg_baud), .tx_data(tx_data), .tx_wr(tx_wr),
        .rx_data(rx_data), .done_irq(done_irq), .dma_req(dma_req), .busy(busy),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .mosi_i(mosi_i), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .ss_n_o(ss_n_o)
    );

    always @(posedge clk) cyc_ct++;
    always @(negedge clk) if (mon_on) begin
        if (done_irq) begin done_cnt++; done_at = cyc_ct; end
        if (dma_req) dma_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // index of the bit on the data line after serial edge i
    function automatic int bit_at(input bit cpha, input int i);
        if (cpha) return (i <= 1) ? 0 : (i - 1) / 2;
        return i / 2;
    endfunction

    task automatic run_master(input bit cpol, input bit cpha, input bit wide, input int baud,
                              input bit dma, input logic [15:0] txv, input logic [15:0] mv,
                              input bit intrude);
        int L = wide ? 16 : 8;
        int D = (baud < 2) ? 2 : baud;
        int fs = cpha ? 2 * L : 2 * L - 1;
        logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
        cfg_baud = 16'(baud); cfg_dma_en = dma; cfg_bcast = 1'b0;
        miso_i = mv[L-1];
        @(negedge clk);
        chk("R1 idle sck", {31'b0, sck_o}, {31'b0, cpol});
        tx_data = txv; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        for (int cyc = 1; cyc <= 2 * L * D + 2; cyc++) begin
            int i;
            bit e_done;
            @(negedge clk);
            i = cyc / D;
            if (i > 2 * L) i = 2 * L;
            e_done = (cyc % D == 0) && (cyc / D == fs);
            chk("R2 sck", {31'b0, sck_o}, {31'b0, cpol ^ i[0]});
            chk("R2 busy", {31'b0, busy}, {31'b0, i < 2 * L});
            chk("R7 done", {31'b0, done_irq}, {31'b0, e_done});
            chk("R8 dma", {31'b0, dma_req}, {31'b0, e_done & dma});
            if (i < 2 * L) begin
                chk("R5 mosi", {31'b0, mosi_o}, {31'b0, txv[L-1-bit_at(cpha, i)]});
                miso_i = mv[L-1-bit_at(cpha, i)];
            end
            if (intrude && cyc == 2) begin tx_data = ~txv; tx_wr = 1'b1; end  // R12
            if (intrude && cyc == 3) tx_wr = 1'b0;
        end
        chk("R6 rx word", {16'b0, rx_data}, {16'b0, mv & mask});
        if (intrude) chk("R12 no restart", {31'b0, busy}, 32'd0);
    endtask

    task automatic run_slave(input bit cpol, input bit cpha, input bit wide, input bit bcast,
                             input bit dma, input logic [15:0] txv, input logic [15:0] mv,
                             input bit abort);
        int L = wide ? 16 : 8;
        int H = 6;
        int t_final = 0;
        logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
        logic [15:0] got = '0;
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide;
        cfg_bcast = bcast; cfg_dma_en = dma; sck_i = cpol; ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        done_cnt = 0; dma_cnt = 0; mon_on = 1'b1;
        if (abort) begin  // R11 partial word, then deselect
            ss_n_i = 1'b0; mosi_i = 1'b1;
            repeat (H) @(negedge clk);
            for (int k = 0; k < 5; k++) begin sck_i = ~sck_i; repeat (H) @(negedge clk); end
            ss_n_i = 1'b1; sck_i = cpol;
            repeat (5) @(negedge clk);
            chk("R11 no done on abort", done_cnt, 0);
        end
        tx_data = txv; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        ss_n_i = 1'b0; mosi_i = mv[L-1];
        repeat (H) @(negedge clk);
        for (int i = 1; i <= 2 * L; i++) begin
            bit is_s = cpha ? (i % 2 == 0) : (i % 2 == 1);
            if (is_s) begin
                got = {got[14:0], miso_o};
                chk("R10 miso_oe", {31'b0, miso_oe}, {31'b0, !bcast});
            end
            sck_i = ~sck_i;
            if (i == (cpha ? 2 * L : 2 * L - 1)) t_final = cyc_ct;
            if (!is_s && i < 2 * L) mosi_i = mv[L-1-bit_at(cpha, i)];
            repeat (H) @(negedge clk);
        end
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        mon_on = 1'b0;
        if (!bcast) chk("R9 slave tx word", {16'b0, got & mask}, {16'b0, txv & mask});
        chk("R9 slave rx word", {16'b0, rx_data}, {16'b0, mv & mask});
        chk("R7 slave one done", done_cnt, 1);
        chk("R9 done latency", done_at - t_final, 3);
        chk("R8 slave dma", dma_cnt, dma ? 1 : 0);
        chk("R10 oe off when deselected", {31'b0, miso_oe}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 done", {31'b0, done_irq}, 32'd0);
        chk("R1 dma", {31'b0, dma_req}, 32'd0);
        chk("R1 rx", {16'b0, rx_data}, 32'd0);
        chk("R1 miso_oe", {31'b0, miso_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 sck idle", {31'b0, sck_o}, {31'b0, cfg_cpol});

        run_master(0, 0, 1, 2, 1, 16'hA53C, 16'h5AC3, 0);  // R2 R6 R8
        run_master(1, 1, 0, 3, 0, 16'h00C5, 16'h003A, 1);  // R4 R12
        run_master(0, 1, 1, 0, 1, 16'h8001, 16'h7FFE, 0);  // R3 baud 0
        run_master(1, 0, 0, 1, 0, 16'hFF96, 16'hFF69, 0);  // R3 baud 1, R4
        run_master(0, 0, 0, 5, 1, 16'h0081, 16'h00E7, 0);  // R5

        run_slave(0, 0, 1, 0, 1, 16'hC3A5, 16'h1E2D, 0);   // R9
        run_slave(1, 1, 0, 0, 0, 16'h005B, 16'h00A4, 0);   // R9 R4
        run_slave(0, 1, 1, 1, 1, 16'h9999, 16'h6CC6, 0);   // R10 broadcast
        run_slave(1, 0, 1, 0, 0, 16'h0F0F, 16'hB00B, 1);   // R11 abort

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule